// File: doc/BRIEF.md
# Clock Generator Power-Down Sequencer

This block controls the ordered shutdown and restart of a clock generator. One control pin has two roles. A configuration bit chooses the role. When the bit is set, the pin is a power-down request: high means run, and low starts the shutdown. When the bit is clear, the pin only selects the clock source, and the sequencer stays in normal operation.

Shutdown always follows the same four steps, one per control clock:
1. Gate the divided output and hold the divider counters in reset.
2. Once the output is seen low, tri-state it.
3. Stop the master clock. The secondary output is stopped and tri-stated as well, unless its keep bit is set.
4. Turn off the oscillator and the input buffer.

When the pin goes high again, the steps are undone in reverse order. A sequence that has started always runs to its end state before the opposite sequence begins.

The pin and the observed output level are asynchronous to the control clock. Each passes through a synchronizer of `SYNC_STAGES` flops before the state machine sees it.

Top module: `clkgen_pwrdn_seq`

## Requirements
- R1: After reset, the block is in normal operation: div_en=1, div_rst=0, div_hiz=0, mclk_en=1, sec_en=1, sec_hiz=0, osc_en=1.
- R2: When cfg_pd_mode=0, the pin starts no sequence and all enables stay as in R1. In that mode src_sel follows the pin level two cycles later. When cfg_pd_mode=1, src_sel is 0.
- R3: With cfg_pd_mode=1, a low pin level gives div_en=0 and div_rst=1 on the third rising clock edge after the change.
- R4: div_hiz rises only after the synchronized output level is low. It rises on the third edge after div_out_lvl falls, once the sequencer is waiting for it. While the level stays high, div_hiz stays 0.
- R5: One edge after div_hiz rises, mclk_en falls. In the same cycle sec_en=0 and sec_hiz=1, but only when cfg_sec_keep=0. When cfg_sec_keep=1, sec_en stays 1 and sec_hiz stays 0.
- R6: One edge after mclk_en falls, osc_en falls. This fully-down state holds for as long as the pin stays low.
- R7: In the fully-down state, a high pin restarts the block in reverse order, one step per edge. The restart begins on the third edge after the pin rises: osc_en rises, then mclk_en and the secondary output return, then div_hiz falls, then div_en=1 and div_rst=0.
- R8: If the pin returns high before the fully-down state is reached, the shutdown still runs to completion. The restart of R7 then follows.
- R9: The sequencer state is one-hot at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_pin | input | 1 | Dual-role pin: power-down request (low) or source select |
| cfg_pd_mode | input | 1 | 1: pin is a power-down request; 0: pin is a source select |
| cfg_sec_keep | input | 1 | 1: the secondary output stays on through shutdown |
| div_out_lvl | input | 1 | Observed level of the divided output |
| src_sel | output | 1 | Synchronized pin level in source-select mode |
| div_en | output | 1 | Divided output gate (1 passes the output) |
| div_rst | output | 1 | Divider counter reset |
| div_hiz | output | 1 | Divided output tri-state |
| mclk_en | output | 1 | Master clock enable |
| sec_en | output | 1 | Secondary output enable |
| sec_hiz | output | 1 | Secondary output tri-state |
| osc_en | output | 1 | Oscillator and input buffer enable |

## Verification
A change on the pin or on the observed level takes two synchronizer edges. The state then moves on the third edge, and every later step follows exactly one edge after the one before it. The bench drives inputs on falling edges and counts edges from that point. It samples the full output vector at the falling edge after each counted rising edge, and checks each step in the cycle where it is due and in the cycle just before it. In the waiting step, the bench holds the level high for a swept number of cycles before releasing it. This shows that the tri-state waits for the level and not for a fixed delay.

// File: rtl/clkgen_pwrdn_seq.sv
module clkgen_pwrdn_seq #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ctl_pin,
  input  logic cfg_pd_mode,
  input  logic cfg_sec_keep,
  input  logic div_out_lvl,
  output logic src_sel,
  output logic div_en,
  output logic div_rst,
  output logic div_hiz,
  output logic mclk_en,
  output logic sec_en,
  output logic sec_hiz,
  output logic osc_en
);

  localparam int S_RUN  = 0;
  localparam int S_GATE = 1;
  localparam int S_WAIT = 2;
  localparam int S_HIZ  = 3;
  localparam int S_CLK  = 4;
  localparam int S_DOWN = 5;
  localparam int NST    = 6;

  logic [SYNC_STAGES-1:0] pin_q, lvl_q;
  logic pin_s, lvl_s, req;
  logic [NST-1:0] st, st_nxt;
  logic up, up_nxt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pin_q <= '1;
      lvl_q <= '1;
    end else begin
      pin_q <= {pin_q[SYNC_STAGES-2:0], ctl_pin};
      lvl_q <= {lvl_q[SYNC_STAGES-2:0], div_out_lvl};
    end

  assign pin_s = pin_q[SYNC_STAGES-1];
  assign lvl_s = lvl_q[SYNC_STAGES-1];
  assign req   = cfg_pd_mode & ~pin_s;

  always_comb begin
    st_nxt = st;
    up_nxt = up;
    unique case (1'b1)
      st[S_RUN]:  if (req) st_nxt = NST'(1) << S_GATE;
      st[S_GATE]: begin
        st_nxt = up ? NST'(1) << S_RUN : NST'(1) << S_WAIT;
        if (up) up_nxt = 1'b0;
      end
      st[S_WAIT]: if (!lvl_s) st_nxt = NST'(1) << S_HIZ;
      st[S_HIZ]:  st_nxt = up ? NST'(1) << S_GATE : NST'(1) << S_CLK;
      st[S_CLK]:  st_nxt = up ? NST'(1) << S_HIZ  : NST'(1) << S_DOWN;
      st[S_DOWN]: if (!req) begin
        st_nxt = NST'(1) << S_CLK;
        up_nxt = 1'b1;
      end
      default:    st_nxt = NST'(1) << S_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= NST'(1) << S_RUN;
      up <= 1'b0;
    end else begin
      st <= st_nxt;
      up <= up_nxt;
    end

  logic clk_off, sec_off;
  assign clk_off = st[S_CLK] | st[S_DOWN];
  assign sec_off = clk_off & ~cfg_sec_keep;

  assign src_sel = ~cfg_pd_mode & pin_s;
  assign div_en  = st[S_RUN];
  assign div_rst = ~st[S_RUN];
  assign div_hiz = st[S_HIZ] | clk_off;
  assign mclk_en = ~clk_off;
  assign sec_en  = ~sec_off;
  assign sec_hiz = sec_off;
  assign osc_en  = ~st[S_DOWN];

endmodule

module clkgen_pwrdn_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       lvl_s,
  input logic [5:0] st,
  input logic       div_en,
  input logic       div_hiz,
  input logic       mclk_en,
  input logic       sec_hiz,
  input logic       osc_en
);
  a_r9_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(st) == 1);
  a_r4_hiz_only_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(div_hiz) |-> !$past(lvl_s));
  a_r3_gate_before_hiz: assert property (@(posedge clk) disable iff (!rst_n)
    div_hiz |-> !div_en);
  a_r5_clk_after_hiz: assert property (@(posedge clk) disable iff (!rst_n)
    !mclk_en |-> div_hiz);
  a_r5_sec_with_clk: assert property (@(posedge clk) disable iff (!rst_n)
    sec_hiz |-> !mclk_en);
  a_r6_osc_last: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(osc_en) |-> $past(!mclk_en));
  a_r7_osc_first: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(osc_en) |-> !mclk_en);
endmodule

bind clkgen_pwrdn_seq clkgen_pwrdn_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .lvl_s(lvl_s), .st(st), .div_en(div_en),
  .div_hiz(div_hiz), .mclk_en(mclk_en), .sec_hiz(sec_hiz), .osc_en(osc_en)
);

// File: tb/test_clkgen_pwrdn_seq.sv
`timescale 1ns/1ps
module test_clkgen_pwrdn_seq;
  logic clk = 1'b0, rst_n = 1'b0;
  logic ctl_pin = 1'b1, cfg_pd_mode = 1'b1, cfg_sec_keep = 1'b0, div_out_lvl = 1'b0;
  logic src_sel, div_en, div_rst, div_hiz, mclk_en, sec_en, sec_hiz, osc_en;
  int total = 0, bad = 0;

  always #2.5 clk = ~clk;

  clkgen_pwrdn_seq i_clkgen_pwrdn_seq (
    .clk(clk), .rst_n(rst_n), .ctl_pin(ctl_pin), .cfg_pd_mode(cfg_pd_mode),
    .cfg_sec_keep(cfg_sec_keep), .div_out_lvl(div_out_lvl), .src_sel(src_sel),
    .div_en(div_en), .div_rst(div_rst), .div_hiz(div_hiz), .mclk_en(mclk_en),
    .sec_en(sec_en), .sec_hiz(sec_hiz), .osc_en(osc_en)
  );

  // vector {osc_en, mclk_en, sec_en, sec_hiz, div_hiz, div_rst, div_en}
  localparam logic [6:0] V_RUN  = 7'b1110001;
  localparam logic [6:0] V_GATE = 7'b1110010;
  localparam logic [6:0] V_HIZ  = 7'b1110110;

  function automatic logic [6:0] v_clk(input logic keep);
    return keep ? 7'b1010110 : 7'b1001110;
  endfunction

  function automatic logic [6:0] v_down(input logic keep);
    return keep ? 7'b0010110 : 7'b0001110;
  endfunction

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [6:0] exp);
    logic [6:0] act;
    act = {osc_en, mclk_en, sec_en, sec_hiz, div_hiz, div_rst, div_en};
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: outputs=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic chk_bit(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  initial begin
    #1000000;
    bad++;
    total++;
    $display("FAIL watchdog: expired, expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    chk("R1", V_RUN);
    rst_n = 1'b1;
    tick(3);
    chk("R1", V_RUN);
    chk_bit("R2", src_sel, 1'b0);

    // R2: source-select mode ignores pin for sequencing
    cfg_pd_mode = 1'b0;
    tick(1);
    chk_bit("R2", src_sel, 1'b1);
    ctl_pin = 1'b0;
    tick(2);
    chk_bit("R2", src_sel, 1'b0);
    for (int i = 0; i < 8; i++) begin
      tick(1);
      chk("R2", V_RUN);
    end
    ctl_pin = 1'b1;
    tick(2);
    chk_bit("R2", src_sel, 1'b1);
    cfg_pd_mode = 1'b1;
    tick(1);
    chk_bit("R2", src_sel, 1'b0);

    // Full shutdown and restart, swept over keep bit and wait length
    for (int keep = 0; keep < 2; keep++) begin
      for (int w = 0; w < 4; w++) begin
        cfg_sec_keep = keep[0];
        ctl_pin = 1'b0;
        div_out_lvl = 1'b1;
        tick(2);
        chk("R3", V_RUN);
        tick(1);
        chk("R3", V_GATE);
        for (int k = 0; k < w; k++) begin
          tick(1);
          chk("R4", V_GATE);
        end
        div_out_lvl = 1'b0;
        tick(2);
        chk("R4", V_GATE);
        tick(1);
        chk("R4", V_HIZ);
        tick(1);
        chk("R5", v_clk(keep[0]));
        tick(1);
        chk("R6", v_down(keep[0]));
        tick(w + 3);
        chk("R6", v_down(keep[0]));
        ctl_pin = 1'b1;
        tick(2);
        chk("R7", v_down(keep[0]));
        tick(1);
        chk("R7", v_clk(keep[0]));
        tick(1);
        chk("R7", V_HIZ);
        tick(1);
        chk("R7", V_GATE);
        tick(1);
        chk("R7", V_RUN);
        tick(2);
        chk("R7", V_RUN);
      end
    end

    // R8: pin returns high before the down state is reached
    for (int keep = 0; keep < 2; keep++) begin
      cfg_sec_keep = keep[0];
      div_out_lvl = 1'b0;
      ctl_pin = 1'b0;
      tick(3);
      chk("R8", V_GATE);
      ctl_pin = 1'b1;
      tick(1);
      chk("R8", V_GATE);
      tick(1);
      chk("R8", V_HIZ);
      tick(1);
      chk("R8", v_clk(keep[0]));
      tick(1);
      chk("R8", v_down(keep[0]));
      tick(1);
      chk("R8", v_clk(keep[0]));
      tick(1);
      chk("R8", V_HIZ);
      tick(1);
      chk("R8", V_GATE);
      tick(1);
      chk("R8", V_RUN);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule